// File: doc/BRIEF.md
# Quadratic Spiking Neuron Step Unit

This block holds the state of one spiking neuron in signed fixed point and advances it by one time step each time a step strobe arrives. The state has two parts: a fast membrane potential and a slow recovery variable. On a strobe the block reads the input current and computes one explicit Euler step for both variables from their old values. The membrane equation is quadratic, and the recovery variable relaxes toward a multiple of the membrane potential. The block then compares the new membrane value with a fixed firing level. When that level is reached, the neuron emits a spike for one clock cycle. At the same time the membrane value is replaced by a programmable reset potential, and the recovery variable is raised by a programmable increment.

A small write-only configuration port sets four coefficients:
- the recovery rate,
- the recovery sensitivity,
- the reset potential,
- the recovery increment after a spike.

All values are signed 16-bit with 8 fractional bits, so 256 counts equal 1.0 (one millivolt for potentials). The time step is a power of two: 2^-DT_SHIFT, with a default of 0.25.

Top module: `izh_neuron`

## Requirements
- R1: While `rst` is high at a rising edge, the coefficient set is loaded with rate=5, sensitivity=51, reset potential=-16640 (-65.0) and increment=2048 (8.0). The state is loaded with v=-16640 and u=((51*-16640)>>>8)=-3315, and `spike` is cleared.
- R2: When `cfg_we` is high at an edge, `cfg_wdata` is written to the coefficient selected by `cfg_addr` (0=rate a, 1=sensitivity b, 2=reset potential c, 3=increment d). The new value is used by steps strobed in later cycles. A step strobed in the same cycle as the write uses the old value.
- R3: On a strobe, the raw membrane value is vr = v + (dv>>>DT_SHIFT), where dv = ((v*v*2621)>>>24) + 5*v + (140<<8) - u + i_in. All terms are computed in wide signed arithmetic, and >>> rounds toward minus infinity.
- R4: On the same strobe, the raw recovery value is ur = u + (du>>>DT_SHIFT), where du = (a*(((b*v)>>>8) - u))>>>8. It uses the v and u from before the step.
- R5: Every stored result is clamped to [-32768, 32767]. This covers the new v, the new u, and u after the increment is added.
- R6: The neuron fires when the clamped new v is at least 7680 (30.0). Then v becomes c, and u becomes clamp(clamped new u + d). If it does not fire, v and u take the clamped new values.
- R7: `spike` goes high in the cycle after the edge that sampled a firing strobe and stays high for exactly that one cycle. It stays low after any non-firing step and after any cycle without a strobe.
- R8: With `step_valid` low, v and u hold their values, even when coefficient writes occur.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| step_valid | input | 1 | Time-step strobe; gates all state updates |
| i_in | input | 16 | Input current, signed Q8.8 |
| cfg_we | input | 1 | Coefficient write enable |
| cfg_addr | input | 2 | Coefficient select (0=a, 1=b, 2=c, 3=d) |
| cfg_wdata | input | 16 | Coefficient value, signed Q8.8 |
| v_out | output | 16 | Membrane potential, signed Q8.8 |
| u_out | output | 16 | Recovery variable, signed Q8.8 |
| spike | output | 1 | One-cycle firing pulse |

## Verification
Each strobe sampled at a rising edge shows its new v, u and spike after that same edge, so every result is due one edge after its stimulus. A coefficient write affects only the strobes of later cycles. Every cycle, the driver pushes the state it expects after the next edge, with step, write and reset ordering applied exactly as the requirements state. The monitor pops one item 2 ns after each rising edge and compares all three outputs. Because every cycle is checked, a spike that lasts too long or appears in an idle cycle is caught. The state right after reset is checked directly once reset is released.

// File: rtl/izh_pkg.sv
package izh_pkg;
    localparam int NW    = 16;   // state and coefficient width
    localparam int NFRAC = 8;    // fractional bits
    localparam int ACC_W = 48;   // wide working width

    typedef logic signed [NW-1:0]    fx_t;
    typedef logic signed [ACC_W-1:0] acc_t;

    typedef enum logic [1:0] {
        SEL_A = 2'd0,
        SEL_B = 2'd1,
        SEL_C = 2'd2,
        SEL_D = 2'd3
    } psel_e;

    typedef struct packed {
        fx_t a;
        fx_t b;
        fx_t c;
        fx_t d;
    } prm_t;

    typedef struct packed {
        fx_t  v;
        fx_t  u;
        logic spk;
    } nstate_t;

    function automatic acc_t widen(input fx_t x);
        return acc_t'(x);
    endfunction

    function automatic fx_t sat_fx(input acc_t x);
        acc_t hi;
        acc_t lo;
        hi = (acc_t'(1) <<< (NW - 1)) - acc_t'(1);
        lo = -(acc_t'(1) <<< (NW - 1));
        if (x > hi)      return fx_t'(hi);
        else if (x < lo) return fx_t'(lo);
        else             return fx_t'(x);
    endfunction
endpackage

// File: rtl/izh_param_regs.sv
module izh_param_regs
    import izh_pkg::*;
#(
    parameter int A_INIT = 5,
    parameter int B_INIT = 51,
    parameter int C_INIT = -16640,
    parameter int D_INIT = 2048
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       we,
    input  logic [1:0] addr,
    input  fx_t        wdata,
    output prm_t       prm
);
    localparam int NFIELD = 4;

    fx_t fld_d [NFIELD];
    fx_t fld_q [NFIELD];

    function automatic fx_t init_of(input int k);
        case (k)
            0:       return fx_t'(A_INIT);
            1:       return fx_t'(B_INIT);
            2:       return fx_t'(C_INIT);
            default: return fx_t'(D_INIT);
        endcase
    endfunction

    for (genvar k = 0; k < NFIELD; k++) begin : g_fld
        always_comb begin
            fld_d[k] = fld_q[k];
            if (we && (addr == 2'(k))) fld_d[k] = wdata;
        end

        always_ff @(posedge clk) begin
            if (rst) fld_q[k] <= init_of(k);
            else     fld_q[k] <= fld_d[k];
        end
    end

    assign prm.a = fld_q[SEL_A];
    assign prm.b = fld_q[SEL_B];
    assign prm.c = fld_q[SEL_C];
    assign prm.d = fld_q[SEL_D];
endmodule

// File: rtl/izh_membrane.sv
module izh_membrane
    import izh_pkg::*;
#(
    parameter int DT_SHIFT = 2,
    parameter int SQ_COEF  = 2621,
    parameter int SQ_FRAC  = 16,
    parameter int LIN_COEF = 5,
    parameter int CONST_MV = 140
) (
    input  fx_t  v_q,
    input  fx_t  u_q,
    input  fx_t  i_cur,
    output acc_t v_raw
);
    localparam acc_t K_SQ      = acc_t'(SQ_COEF);
    localparam acc_t K_LIN     = acc_t'(LIN_COEF);
    localparam acc_t REST_BIAS = acc_t'(CONST_MV) <<< NFRAC;
    localparam int   SQ_SHIFT  = NFRAC + SQ_FRAC;

    acc_t v_w;
    acc_t sq;
    acc_t quad;
    acc_t lin;
    acc_t dv;

    always_comb begin
        v_w   = widen(v_q);
        sq    = v_w * v_w;
        quad  = (sq * K_SQ) >>> SQ_SHIFT;
        lin   = v_w * K_LIN;
        dv    = quad + lin + REST_BIAS - widen(u_q) + widen(i_cur);
        v_raw = v_w + (dv >>> DT_SHIFT);
    end
endmodule

// File: rtl/izh_recovery.sv
module izh_recovery
    import izh_pkg::*;
#(
    parameter int DT_SHIFT = 2
) (
    input  fx_t  v_q,
    input  fx_t  u_q,
    input  fx_t  rate,
    input  fx_t  sens,
    output acc_t u_raw
);
    acc_t bv;
    acc_t du;

    always_comb begin
        bv    = (widen(sens) * widen(v_q)) >>> NFRAC;
        du    = (widen(rate) * (bv - widen(u_q))) >>> NFRAC;
        u_raw = widen(u_q) + (du >>> DT_SHIFT);
    end
endmodule

// File: rtl/izh_neuron.sv
module izh_neuron
    import izh_pkg::*;
#(
    parameter int DT_SHIFT  = 2,
    parameter int SQ_COEF   = 2621,
    parameter int SQ_FRAC   = 16,
    parameter int LIN_COEF  = 5,
    parameter int CONST_MV  = 140,
    parameter int THRESH_MV = 30,
    parameter int A_INIT    = 5,
    parameter int B_INIT    = 51,
    parameter int C_INIT    = -16640,
    parameter int D_INIT    = 2048
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 step_valid,
    input  logic signed [15:0]   i_in,
    input  logic                 cfg_we,
    input  logic [1:0]           cfg_addr,
    input  logic signed [15:0]   cfg_wdata,
    output logic signed [15:0]   v_out,
    output logic signed [15:0]   u_out,
    output logic                 spike
);
    localparam fx_t THRESH_FX = fx_t'(THRESH_MV <<< NFRAC);
    localparam fx_t V_RST     = fx_t'(C_INIT);
    localparam fx_t U_RST     = sat_fx((acc_t'(B_INIT) * acc_t'(C_INIT)) >>> NFRAC);

    prm_t    prm;
    acc_t    v_raw;
    acc_t    u_raw;
    fx_t     v_sat;
    fx_t     u_sat;
    logic    fire;
    fx_t     par_c;
    nstate_t st_d;
    nstate_t st_q;

    izh_param_regs #(
        .A_INIT(A_INIT),
        .B_INIT(B_INIT),
        .C_INIT(C_INIT),
        .D_INIT(D_INIT)
    ) u_prm (
        .clk  (clk),
        .rst  (rst),
        .we   (cfg_we),
        .addr (cfg_addr),
        .wdata(cfg_wdata),
        .prm  (prm)
    );

    izh_membrane #(
        .DT_SHIFT(DT_SHIFT),
        .SQ_COEF (SQ_COEF),
        .SQ_FRAC (SQ_FRAC),
        .LIN_COEF(LIN_COEF),
        .CONST_MV(CONST_MV)
    ) u_mem (
        .v_q  (st_q.v),
        .u_q  (st_q.u),
        .i_cur(i_in),
        .v_raw(v_raw)
    );

    izh_recovery #(
        .DT_SHIFT(DT_SHIFT)
    ) u_rec (
        .v_q  (st_q.v),
        .u_q  (st_q.u),
        .rate (prm.a),
        .sens (prm.b),
        .u_raw(u_raw)
    );

    assign par_c = prm.c;

    always_comb begin
        v_sat    = sat_fx(v_raw);
        u_sat    = sat_fx(u_raw);
        fire     = (v_sat >= THRESH_FX);
        st_d     = st_q;
        st_d.spk = 1'b0;
        if (step_valid) begin
            if (fire) begin
                st_d.v   = prm.c;
                st_d.u   = sat_fx(widen(u_sat) + widen(prm.d));
                st_d.spk = 1'b1;
            end else begin
                st_d.v = v_sat;
                st_d.u = u_sat;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.v   <= V_RST;
            st_q.u   <= U_RST;
            st_q.spk <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign v_out = st_q.v;
    assign u_out = st_q.u;
    assign spike = st_q.spk;
endmodule

// File: rtl/izh_neuron_chk.sv
module izh_neuron_chk
    import izh_pkg::*;
#(
    parameter int THRESH_MV = 30,
    parameter int C_INIT    = -16640
) (
    input logic clk,
    input logic rst,
    input logic step_valid,
    input fx_t  v_out,
    input fx_t  u_out,
    input logic spike,
    input fx_t  par_c
);
    localparam fx_t THR = fx_t'(THRESH_MV <<< NFRAC);

    // R1: first cycle after reset shows the reset potential and no spike
    a_r1_reset_state: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (v_out == fx_t'(C_INIT)) && !spike);

    // R7: a spike only follows a sampled strobe
    a_r7_spike_needs_step: assert property (@(posedge clk) disable iff (rst)
        spike |-> $past(step_valid));

    // R6: a firing step leaves v at the reset potential in force before the edge
    a_r6_spike_sets_v: assert property (@(posedge clk) disable iff (rst)
        spike |-> (v_out == $past(par_c)));

    // R6: a non-firing step leaves v under the firing level
    a_r6_quiet_below_thr: assert property (@(posedge clk) disable iff (rst)
        ($past(step_valid) && !$past(rst) && !spike) |-> (v_out < THR));

    // R8: no strobe, no change
    a_r8_hold_when_idle: assert property (@(posedge clk) disable iff (rst)
        (!$past(step_valid) && !$past(rst)) |-> ($stable(v_out) && $stable(u_out) && !spike));
endmodule

bind izh_neuron izh_neuron_chk #(
    .THRESH_MV(THRESH_MV),
    .C_INIT   (C_INIT)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .step_valid(step_valid),
    .v_out     (v_out),
    .u_out     (u_out),
    .spike     (spike),
    .par_c     (par_c)
);

// File: tb/izh_neuron_test.sv
`timescale 1ns/1ps
module izh_neuron_test;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic step_valid = 1'b0;
    logic signed [15:0] i_in = '0;
    logic cfg_we = 1'b0;
    logic [1:0] cfg_addr = '0;
    logic signed [15:0] cfg_wdata = '0;
    logic signed [15:0] v_out;
    logic signed [15:0] u_out;
    logic spike;

    always #5 clk = ~clk;

    izh_neuron uut (
        .clk(clk), .rst(rst), .step_valid(step_valid), .i_in(i_in),
        .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .v_out(v_out), .u_out(u_out), .spike(spike)
    );

    typedef struct {
        longint v;
        longint u;
        bit     s;
        string  tag;
    } exp_t;

    exp_t   sb[$];
    int     total = 0;
    int     bad = 0;
    int     seen_spikes = 0;
    int     model_spikes = 0;
    bit     finished = 0;
    longint mv, mu, pa, pb, pc, pd;

    function automatic longint clamp16(input longint x);
        if (x > 32767)  return 32767;
        if (x < -32768) return -32768;
        return x;
    endfunction

    task automatic model_reset();
        pa = 5; pb = 51; pc = -16640; pd = 2048;
        mv = pc;
        mu = clamp16((pb * pc) >>> 8);
    endtask

    task automatic check_now(input string tag, input longint ev, input longint eu, input bit es);
        total++;
        if (longint'(v_out) != ev || longint'(u_out) != eu || spike != es) begin
            bad++;
            $display("FAIL %s: v=%0d u=%0d spike=%0d expected v=%0d u=%0d spike=%0d",
                     tag, v_out, u_out, spike, ev, eu, es);
        end
    endtask

    // driver: one call per cycle, starting at a falling edge
    task automatic drive(input bit stp, input longint cur, input bit we,
                         input int adr, input longint dat, input string tag);
        exp_t e;
        longint dv, vn, bv, du, un, vs, us;
        bit fired;
        step_valid = stp;
        i_in       = 16'(cur);
        cfg_we     = we;
        cfg_addr   = 2'(adr);
        cfg_wdata  = 16'(dat);
        fired = 0;
        if (stp) begin
            // R3 membrane, R4 recovery, R5 clamp, R6 firing
            dv = ((mv * mv * 2621) >>> 24) + 5 * mv + (140 <<< 8) - mu + cur;
            vn = mv + (dv >>> 2);
            bv = (pb * mv) >>> 8;
            du = (pa * (bv - mu)) >>> 8;
            un = mu + (du >>> 2);
            vs = clamp16(vn);
            us = clamp16(un);
            if (vs >= 7680) begin
                mv = pc;
                mu = clamp16(us + pd);
                fired = 1;
                model_spikes++;
            end else begin
                mv = vs;
                mu = us;
            end
        end
        // R2: the write lands after the step has used the old value
        if (we) begin
            case (adr)
                0: pa = dat;
                1: pb = dat;
                2: pc = dat;
                default: pd = dat;
            endcase
        end
        e.v = mv; e.u = mu; e.s = fired; e.tag = tag;
        sb.push_back(e);
        @(negedge clk);
    endtask

    // monitor: result is due after the rising edge that follows the drive
    always begin
        @(posedge clk);
        #2;
        if (sb.size() > 0) begin
            exp_t e;
            e = sb.pop_front();
            if (spike) seen_spikes++;
            check_now(e.tag, e.v, e.u, e.s);
        end
    end

    task automatic apply_reset(input string tag);
        rst = 1'b1;
        step_valid = 1'b0;
        cfg_we = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        model_reset();
        check_now(tag, mv, mu, 1'b0);
    endtask

    initial begin
        #1_000_000;
        if (!finished) begin
            bad++;
            total++;
            $display("FAIL watchdog: run did not finish, actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        apply_reset("R1 reset state");

        // R3 R4 R6 R7: constant drive of 10.0 with default coefficients
        for (int k = 0; k < 300; k++) drive(1, 10 <<< 8, 0, 0, 0, "R3/R4/R6/R7 tonic");
        total++;
        if (model_spikes == 0 || seen_spikes != model_spikes) begin
            bad++;
            $display("FAIL R6: spikes seen=%0d expected=%0d (nonzero)", seen_spikes, model_spikes);
        end

        // R8: idle cycles with coefficient writes leave state alone
        drive(0, 20 <<< 8, 1, 0, 10, "R8 idle write a");
        drive(0, 20 <<< 8, 1, 1, 64, "R8 idle write b");
        drive(0, 0, 0, 0, 0, "R8 idle");
        drive(0, 0, 1, 2, -12800, "R8 idle write c");
        drive(0, 0, 1, 3, 512, "R8 idle write d");

        // R2: new coefficients in force; write c during a step
        for (int k = 0; k < 60; k++) drive(1, 15 <<< 8, 0, 0, 0, "R2 new coefficients");
        for (int k = 0; k < 40; k++)
            drive(1, 25 <<< 8, (k % 7) == 3, 2, (k % 2) ? -15000 : -12000, "R2 write with step");

        // R5 R6: huge increment saturates u; strong drive saturates raw v
        drive(0, 0, 1, 3, 32767, "R5 set d max");
        drive(0, 0, 1, 2, 0, "R5 set c zero");
        for (int k = 0; k < 40; k++) drive(1, 32767, 0, 0, 0, "R5 saturation high");

        // R5: strongly negative drive from a low reset potential
        drive(0, 0, 1, 2, -30000, "R5 set c low");
        drive(0, 0, 1, 3, -32768, "R5 set d min");
        drive(0, 0, 1, 0, 200, "R5 set a");
        for (int k = 0; k < 60; k++) drive(1, -32768, 0, 0, 0, "R5 saturation low");

        // R7: alternate strobes and idle cycles around firing
        drive(0, 0, 1, 3, 2048, "R7 set d");
        drive(0, 0, 1, 2, -16640, "R7 set c");
        drive(0, 0, 1, 0, 5, "R7 set a");
        for (int k = 0; k < 200; k++) drive(k % 2, 40 <<< 8, 0, 0, 0, "R7 pulse width");

        // R1: reset mid-run restores defaults
        apply_reset("R1 reset again");
        for (int k = 0; k < 20; k++) drive(1, 10 <<< 8, 0, 0, 0, "R1 defaults after reset");

        repeat (3) @(negedge clk);
        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule